// File: doc/BRIEF.md
# Integer ALU with Signed-Overflow Flag

This block is the integer arithmetic and logic unit of a small load-store processor. Each clock it takes two 32-bit operands, a 5-bit shift amount and a 4-bit operation code. It returns a 32-bit result, a zero flag for equal/not-equal branch decisions, and a signed-overflow flag. The processor's exception logic uses that flag to trap on signed add and subtract.

The unit covers add, subtract, AND, OR, XOR, NOR, signed set-on-less-than and logical left shift. It also has unsigned add and subtract forms. These give the same result bits as the signed forms but never raise the overflow flag. The result and flags are registered, so they appear one clock after the operands are presented. A synchronous active-high reset clears them.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (signed add) returns A+B modulo 2^32. The overflow flag is 1 exactly when the true signed sum lies outside the 32-bit two's-complement range.
- R2: Operation code 2 (signed subtract) returns A-B modulo 2^32. The overflow flag is 1 exactly when the true signed difference lies outside the 32-bit two's-complement range.
- R3: Operation codes 1 (unsigned add) and 3 (unsigned subtract) return the same bits as codes 0 and 2, with the overflow flag always 0.
- R4: Operation codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B), with the overflow flag 0.
- R5: Operation code 8 returns 1 when A is less than B as signed 32-bit values and 0 otherwise. This holds also where A-B overflows. The overflow flag is 0.
- R6: Operation code 9 returns B shifted left by the shift amount (0 to 31), with zeros filled in from the right and the overflow flag 0.
- R7: For operation codes 0 to 9, the zero flag is 1 exactly when the 32-bit result is zero.
- R8: Operation codes 10 to 15 return a result of zero with both flags 0.
- R9: The result and flags update on the rising clock edge after the inputs are presented and hold until the next edge. While reset is high at an edge, they become zero with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (also the value shifted by code 9) |
| shamt_i | input | 5 | Left shift amount |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The hardest corner is set-on-less-than when A-B overflows. In that case the sign of the raw difference gives the wrong answer. Random operands rarely produce it, so the stimulus pairs the most negative and most positive values with small operands of the opposite sign. The same extreme pairs drive signed add and subtract just across and just short of the overflow boundary. Random operands over all sixteen codes then cover the undefined codes and the general case against a reference that works in 64-bit signed integers.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLL  = 4'd9
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    // Operand signs as the adder sees them must agree, and the result sign must then differ.
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    // The signed order follows from the difference sign corrected by overflow.
    lt    = sum[W-1] ^ ovf;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   d,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   y
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = d;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][W-1-STEP:0], {STEP{1'b0}}} : stage[s];
  end

  assign y = stage[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o,
  output logic           ovf_o
);
  localparam logic [W-1:0] ZERO_W = '0;

  logic         do_sub;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic         as_lt;
  logic [W-1:0] lg_y;
  logic [W-1:0] sh_y;
  logic_sel_e   lg_sel;
  logic [W-1:0] res_c;
  logic         ovf_c;
  logic         zero_c;
  logic         op_ok;

  always_comb begin
    do_sub = (op_i == OP_SUB) || (op_i == OP_SUBU) || (op_i == OP_SLT);
    lg_sel = logic_sel_e'(op_i[1:0]);
    op_ok  = (op_i <= OP_LAST);
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(a_i), .b(b_i), .sub(do_sub),
    .sum(as_sum), .ovf(as_ovf), .lt(as_lt)
  );

  alu_logic #(.W(W)) u_logic (
    .a(a_i), .b(b_i), .sel(lg_sel), .y(lg_y)
  );

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .d(b_i), .amt(shamt_i), .y(sh_y)
  );

  always_comb begin
    res_c = ZERO_W;
    ovf_c = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res_c = as_sum;
        ovf_c = as_ovf;
      end
      OP_ADDU, OP_SUBU: res_c = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: res_c = lg_y;
      OP_SLT: res_c = {{(W-1){1'b0}}, as_lt};
      OP_SLL: res_c = sh_y;
      default: res_c = ZERO_W;
    endcase
    zero_c = op_ok && (res_c == ZERO_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= ZERO_W;
      zero_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      res_o  <= res_c;
      zero_o <= zero_c;
      ovf_o  <= ovf_c;
    end
  end

  // R3/R4/R5/R6: only the trapping add and subtract may raise overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(op_i == OP_ADD || op_i == OP_SUB) |=> !ovf_o);

  // R8: undefined codes give a quiet zero
  p_undef_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_LAST) |=> (res_o == ZERO_W && !zero_o && !ovf_o));

  // R7: zero flag never set on a nonzero result
  p_zero_match_r7: assert property (@(posedge clk) disable iff (rst)
    zero_o |-> (res_o == ZERO_W));

  // R5: set-on-less-than yields only 0 or 1
  p_slt_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLT) |=> (res_o[W-1:1] == '0));

  // R1: signed add of operands with different signs never overflows
  p_add_mixed_r1: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD && a_i[W-1] != b_i[W-1]) |=> !ovf_o);

  // R6: a zero shift returns B unchanged
  p_sll_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLL && shamt_i == '0) |=> (res_o == $past(b_i)));
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] res_o;
  logic        zero_o;
  logic        ovf_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] prev_res = '0;
  logic        prev_z   = 1'b0;
  logic        prev_v   = 1'b0;

  int_alu uut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .res_o(res_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd2: return "R2";
      4'd1, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, output logic [31:0] r, output logic z,
                       output logic v);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    v = 1'b0;
    r = '0;
    case (op)
      4'd0, 4'd1: begin
        t = sa + sb; r = t[31:0];
        if (op == 4'd0) v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        t = sa - sb; r = t[31:0];
        if (op == 4'd2) v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd8: r = (sa < sb) ? 32'd1 : 32'd0;
      4'd9: begin
        r = b;
        for (int i = 0; i < 32; i++) if (i < int'(sh)) r = {r[30:0], 1'b0};
      end
      default: r = '0;
    endcase
    z = (op <= 4'd9) && (r == 32'd0);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    logic [31:0] er;
    logic ez, ev;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    #1;
    // R9: outputs hold until the next rising edge
    chk("R9", "hold", res_o, prev_res);
    model(op, a, b, sh, er, ez, ev);
    @(negedge clk);
    chk(tag_of(op), "result", res_o, er);
    chk(ez ? "R7" : tag_of(op), "zero", {31'd0, zero_o}, {31'd0, ez});
    chk(tag_of(op), "overflow", {31'd0, ovf_o}, {31'd0, ev});
    prev_res = er; prev_z = ez; prev_v = ev;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    op_i = 4'd0; a_i = 32'hFFFF_FFFF; b_i = 32'h1;
    repeat (3) @(negedge clk);
    // R9: reset clears outputs
    chk("R9", "reset result", res_o, 32'd0);
    chk("R9", "reset zero", {31'd0, zero_o}, 32'd0);
    chk("R9", "reset ovf", {31'd0, ovf_o}, 32'd0);
    rst = 1'b0;
    prev_res = '0;

    // R1 boundaries
    apply(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0);
    apply(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0);
    apply(4'd0, 32'h7FFF_FFFE, 32'h1, 5'd0);
    apply(4'd0, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    apply(4'd0, 32'h0000_0005, 32'hFFFF_FFFB, 5'd0);
    // R2 boundaries
    apply(4'd2, 32'h8000_0000, 32'h1, 5'd0);
    apply(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    apply(4'd2, 32'h0, 32'h8000_0000, 5'd0);
    apply(4'd2, 32'h1234_5678, 32'h1234_5678, 5'd0);
    // R3 same bits, no overflow
    apply(4'd1, 32'h7FFF_FFFF, 32'h1, 5'd0);
    apply(4'd3, 32'h8000_0000, 32'h1, 5'd0);
    // R4
    apply(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
    apply(4'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
    apply(4'd6, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 5'd0);
    apply(4'd7, 32'h0, 32'h0, 5'd0);
    apply(4'd7, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
    // R5 including overflowing differences
    apply(4'd8, 32'h8000_0000, 32'h1, 5'd0);
    apply(4'd8, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    apply(4'd8, 32'hFFFF_FFFF, 32'h0, 5'd0);
    apply(4'd8, 32'h5, 32'h5, 5'd0);
    // R6
    apply(4'd9, 32'h0, 32'h0000_0007, 5'd2);
    apply(4'd9, 32'h0, 32'h8000_0001, 5'd0);
    apply(4'd9, 32'h0, 32'h0000_0003, 5'd31);
    // R8
    for (int c = 10; c < 16; c++) apply(4'(c), 32'h0, 32'h0, 5'd0);
    apply(4'd15, 32'h7FFF_FFFF, 32'h1, 5'd3);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 7 == 0) ra = {ra[31], 31'h7FFF_FFF0 | ra[3:0]};
      if (k % 11 == 0) rb = ra;
      apply(4'($urandom_range(0, 15)), ra, rb, 5'($urandom_range(0, 31)));
    end

    // R9: reset in mid-run clears outputs
    @(negedge clk);
    op_i = 4'd5; a_i = 32'hFFFF_FFFF; b_i = 32'h0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9", "mid reset result", res_o, 32'd0);
    chk("R9", "mid reset ovf", {31'd0, ovf_o}, 32'd0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule